// File: doc/BRIEF.md
# Shadow Scan Capture for Multi-Core Thread State

This block gives a test port a way to look at one hardware thread's architectural state in several processor cores while those cores keep running. A family of private test instructions chooses the operation. The upper bits of the instruction word mark shadow scanning, and the low three bits choose one of eight thread IDs. That thread ID goes to every core at all times.

On the capture strobe, every enabled core copies the chosen thread's state snapshot into its own shadow chain, all in the same clock edge. The live state buses are only read, never written or held. The shift strobe then moves the chains out serially, least significant bit first, with core 0 nearest the test data output. A disabled core is left out of the path, so the scan length is the snapshot width times the number of enabled cores. The enable mask is sampled at capture time and stays fixed for the whole shift sequence. If the instruction is not a shadow scan instruction, the data path falls back to a one-bit bypass register.

Top module: `shsc_top`

## Requirements
- R1: An instruction word whose bits [7:3] equal the prefix parameter (default 5'b10110) selects shadow scan. Bits [2:0] of that word are the thread ID.
- R2: On a clock with `capture_dr` high and a matching instruction, every core whose `core_en` bit is 1 loads the snapshot of the selected thread. The snapshot of core c, thread t sits at `core_state[(c*8+t)*STATE_W +: STATE_W]`.
- R3: With a matching instruction, each clock with `shift_dr` high moves the path one bit toward `tdo`. `tdo` is registered: after the k-th shift edge (counting from 0), it shows stream bit k. The stream is the bits of the enabled cores in ascending core order, each core LSB first.
- R4: Disabled cores are skipped. The path length L is STATE_W times the number of enabled cores. A `tdi` bit applied at shift edge j appears on `tdo` after edge j+L, so with no core enabled `tdi` appears after the same edge.
- R5: The enable mask used for the path is the one sampled at the last matching capture. Changes to `core_en` after that have no effect on the shifted data or its length.
- R6: Shadow contents change only on a matching capture or a matching shift. Changes to `core_state` after a capture do not alter the shifted data.
- R7: With a non-matching instruction, capture and shift leave the shadow chains untouched, and `tdo` comes from a one-bit bypass register. That register loads 0 at capture and loads `tdi` on each shift, so the first shift edge gives 0 and each later edge gives the `tdi` of the previous shift edge.
- R8: Synchronous reset clears `tdo`, the shadow chains and the sampled mask. Before any capture, a matching shift therefore passes `tdi` straight through to `tdo`.
- R9: `tdo` holds its value on every clock where `shift_dr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_value | input | IR_W | Current test instruction |
| capture_dr | input | 1 | Capture strobe for the data register |
| shift_dr | input | 1 | Shift strobe for the data register |
| tdi | input | 1 | Serial test data in |
| core_en | input | NUM_CORES | Per-core enable bits |
| core_state | input | NUM_CORES*8*STATE_W | Per-core, per-thread state snapshots |
| tdo | output | 1 | Registered serial test data out |

## Verification
The bench builds the block with NUM_CORES=3 and STATE_W=8. That makes the full path 24 bits long, and every one of the eight enable masks, including all-disabled and single-core ones, can be reached in a few hundred cycles. Random thread IDs, masks and state images are run together with directed cases. The directed cases cover changing the mask and state during a shift, bypass operation between capture and shift, and a shift right after reset.

// File: rtl/shsc_pkg.sv
package shsc_pkg;
  localparam int THREADS = 8;
  localparam int TID_W   = $clog2(THREADS);
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/shsc_ir_decode.sv
module shsc_ir_decode
  import shsc_pkg::*;
#(
  parameter int IR_W = 8,
  parameter logic [IR_W-TID_W-1:0] PREFIX = 5'b10110
) (
  input  logic [IR_W-1:0] ir,
  output logic            match,
  output tid_t            tid
);
  assign match = (ir[IR_W-1:TID_W] == PREFIX);
  assign tid   = ir[TID_W-1:0];
endmodule

// File: rtl/shsc_core_chain.sv
module shsc_core_chain
  import shsc_pkg::*;
#(
  parameter int STATE_W = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [THREADS*STATE_W-1:0] threads_in,
  input  tid_t                       tid,
  input  logic                       cap,
  input  logic                       shift,
  input  logic                       en_now,
  input  logic                       sin,
  output logic                       sout
);
  logic [STATE_W-1:0] snap;
  logic [STATE_W-1:0] sr;
  logic               en_q;

  assign snap = threads_in[int'(tid)*STATE_W +: STATE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      en_q <= 1'b0;
    end else if (cap) begin
      en_q <= en_now;
      if (en_now) sr <= snap;
    end else if (shift && en_q) begin
      sr <= {sin, sr[STATE_W-1:1]};
    end
  end

  assign sout = en_q ? sr[0] : sin;

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap && !shift) |=> $stable(sr));
  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && en_now) |=> (sr == $past(snap)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(en_q));
endmodule

// File: rtl/shsc_top.sv
module shsc_top
  import shsc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int STATE_W   = 64,
  parameter int IR_W      = 8,
  parameter logic [IR_W-TID_W-1:0] PREFIX = 5'b10110
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [IR_W-1:0]                      ir_value,
  input  logic                                 capture_dr,
  input  logic                                 shift_dr,
  input  logic                                 tdi,
  input  logic [NUM_CORES-1:0]                 core_en,
  input  logic [NUM_CORES*THREADS*STATE_W-1:0] core_state,
  output logic                                 tdo
);
  localparam int CORE_BITS = THREADS * STATE_W;

  logic ir_match;
  tid_t sel_tid;
  logic [NUM_CORES:0] link;
  logic byp_q;

  shsc_ir_decode #(.IR_W(IR_W), .PREFIX(PREFIX)) u_dec (
    .ir(ir_value), .match(ir_match), .tid(sel_tid)
  );

  assign link[NUM_CORES] = tdi;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    shsc_core_chain #(.STATE_W(STATE_W)) u_chain (
      .clk(clk),
      .rst(rst),
      .threads_in(core_state[c*CORE_BITS +: CORE_BITS]),
      .tid(sel_tid),
      .cap(capture_dr && ir_match),
      .shift(shift_dr && ir_match),
      .en_now(core_en[c]),
      .sin(link[c+1]),
      .sout(link[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdo   <= 1'b0;
      byp_q <= 1'b0;
    end else if (capture_dr) begin
      if (!ir_match) byp_q <= 1'b0;
    end else if (shift_dr) begin
      if (ir_match) begin
        tdo <= link[0];
      end else begin
        tdo   <= byp_q;
        byp_q <= tdi;
      end
    end
  end

  // R9
  tdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_dr |=> $stable(tdo));
  // R7
  bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(capture_dr && !ir_match) && shift_dr && !capture_dr && !ir_match) |=> (tdo == 1'b0));
endmodule

// File: tb/shsc_top_tb.sv
module shsc_top_tb;
  localparam int NC = 3;
  localparam int W  = 8;
  localparam int SB = NC * 8 * W;
  localparam logic [7:0] BYP = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ir_value = BYP;
  logic capture_dr = 1'b0, shift_dr = 1'b0, tdi = 1'b0;
  logic [NC-1:0] core_en = '0;
  logic [SB-1:0] core_state = '0;
  logic tdo;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shsc_top #(.NUM_CORES(NC), .STATE_W(W)) u_dut (
    .clk(clk), .rst(rst), .ir_value(ir_value), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .tdi(tdi), .core_en(core_en),
    .core_state(core_state), .tdo(tdo)
  );

  function automatic logic [7:0] sh_ir(input int tid);
    return {5'b10110, 3'(tid)};
  endfunction

  function automatic int chain_len(input logic [NC-1:0] m);
    int n = 0;
    for (int c = 0; c < NC; c++) if (m[c]) n += W;
    return n;
  endfunction

  function automatic logic stream_bit(input logic [SB-1:0] s, input logic [NC-1:0] m,
                                      input int tid, input int j);
    int k = j;
    for (int c = 0; c < NC; c++) begin
      if (m[c]) begin
        if (k < W) return s[(c*8+tid)*W + k];
        k -= W;
      end
    end
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: tdo=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic randomize_state();
    for (int i = 0; i < SB; i += 32) core_state[i +: 32] = $urandom;
  endtask

  task automatic do_capture(input logic [7:0] ir);
    @(negedge clk);
    ir_value = ir; capture_dr = 1'b1;
    @(negedge clk);
    capture_dr = 1'b0;
  endtask

  // Shift L+extra bits and compare against the captured stream then tdi echo.
  task automatic scan_check(input string req, input logic [SB-1:0] snap,
                            input logic [NC-1:0] m, input int tid,
                            input int extra, input bit perturb);
    int L = chain_len(m);
    logic tdis [0:127];
    logic exp;
    for (int j = 0; j < L + extra; j++) begin
      tdis[j] = 1'($urandom);
      shift_dr = 1'b1; tdi = tdis[j];
      if (perturb && j == 2) begin
        core_en = ~m;
        randomize_state();
      end
      @(negedge clk);
      exp = (j < L) ? stream_bit(snap, m, tid, j) : tdis[j-L];
      check(req, tdo, exp);
    end
    shift_dr = 1'b0;
  endtask

  task automatic run_scan(input string req, input int tid, input logic [NC-1:0] m,
                          input bit perturb);
    logic [SB-1:0] snap;
    randomize_state();
    core_en = m;
    snap = core_state;
    do_capture(sh_ir(tid));
    scan_check(req, snap, m, tid, 4, perturb);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [SB-1:0] snap0;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state, then pass-through with no core enabled
    check("R8 reset tdo", tdo, 1'b0);
    ir_value = sh_ir(0);
    scan_check("R8 R4 empty path after reset", '0, '0, 0, 5, 0);

    // R1 R2 R3: all cores, every thread
    for (int t = 0; t < 8; t++) run_scan("R1 R2 R3 full path", t, 3'b111, 0);
    // R4: every mask including none and single core
    for (int mk = 0; mk < 8; mk++) run_scan("R4 mask skip", mk % 8, 3'(mk), 0);
    // random mix
    for (int i = 0; i < 20; i++)
      run_scan("R2 R3 R4 random", int'($urandom_range(0, 7)), 3'($urandom), 0);
    // R5 R6: mask and state changed mid-shift
    run_scan("R5 R6 mid-shift change", 5, 3'b101, 1);
    run_scan("R5 R6 mid-shift change", 2, 3'b011, 1);

    // R7: bypass behaviour
    do_capture(BYP);
    prev = 1'b0;
    for (int j = 0; j < 6; j++) begin
      logic b = 1'($urandom);
      shift_dr = 1'b1; tdi = b;
      @(negedge clk);
      check("R7 bypass", tdo, prev);
      prev = b;
    end
    shift_dr = 1'b0;

    // R7: shadow untouched by non-matching capture and shift
    randomize_state();
    core_en = 3'b111;
    snap0 = core_state;
    do_capture(sh_ir(6));
    randomize_state();
    core_en = 3'b001;
    do_capture(BYP);
    for (int j = 0; j < 5; j++) begin
      shift_dr = 1'b1; tdi = 1'($urandom);
      @(negedge clk);
    end
    shift_dr = 1'b0;
    ir_value = sh_ir(6);
    scan_check("R7 shadow kept under bypass", snap0, 3'b111, 6, 2, 0);

    // R9: tdo holds with shift low
    prev = tdo;
    tdi = ~tdi;
    repeat (3) @(negedge clk);
    check("R9 hold", tdo, prev);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule